// File: doc/BRIEF.md
# Frame-Synchronized Multi-Mode PWM Dimmer

This block produces sixteen independent enable waveforms for LED strings. A processed frame-sync strobe starts each frame, and all timing inside a frame is counted in pulses of a processed grayscale clock enable, not in system clock cycles. Each string has an on-time, a phase delay and a two-bit alignment mode. The mode decides where the pulse sits: it can start after the delay, be centred on the delay, end a delay past the next frame start, or end a delay before it. One global intensity value scales every on-time.

Configuration arrives through a plain write port into shadow registers. Each sync strobe copies the shadows into the active set, so a frame never sees a half-written setup. The length of the frame that just ended is captured at every sync. The two end-anchored modes measure from that captured length. A bypass setting, also loaded at sync, makes every string follow an external PWM input.

Top module: `frame_pwm_dimmer`

## Requirements
- R1: After reset all string outputs are low and stay low until a sync strobe loads a configuration with a non-zero effective on-time.
- R2: Writes land in shadow registers. Outputs keep following the previously loaded values until the next cycle with `sync_i` high, and that edge loads the shadows into the active set.
- R3: The frame position is 0 in the cycle after a sync edge and advances by one for each cycle with `gs_en_i` high (sync has priority). The position saturates at 4095. At each sync edge the frame length becomes the position reached just before that edge.
- R4: Mode 0 (forward): the string is high for positions p with delay <= p < delay + eff.
- R5: Mode 1 (centre): with h = eff/2 (truncated), rise = max(delay - h, 0) and fall = delay + eff - h. The string is high for rise <= p < fall.
- R6: Mode 2 (reverse): fall = flen + delay and rise = max(fall - eff, 0), where flen is the captured frame length. The string is high for rise <= p < fall.
- R7: Mode 3 (inverse): fall = max(flen - delay, 0) and rise = max(fall - eff, 0). The string is high for rise <= p < fall.
- R8: The effective on-time is eff = (on_time * intensity) >> 12, truncated. An intensity of 0 keeps every string low.
- R9: If eff = 0 the string stays low for the whole frame. A pulse that would run past the frame end is cut at the next sync, which restarts the position.
- R10: When the loaded bypass bit is 1, every output equals `ext_pwm_i` combinationally, whatever the string settings are.
- R11: The register map uses the address for string n as follows. Address 2n holds the on-time in bits [11:0]. Address 2n+1 holds the delay in bits [11:0] and the mode in bits [13:12]. Address 32 holds the intensity in bits [11:0], and bit 0 of address 33 is bypass. Writes to addresses 34 and above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Processed frame-sync strobe, one cycle per frame |
| gs_en_i | input | 1 | Processed grayscale clock enable, one position step per high cycle |
| ext_pwm_i | input | 1 | External PWM level used in bypass |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Register write address |
| wr_data_i | input | 14 | Register write data |
| str_o | output | 16 | String enable outputs |

## Verification
Each alignment mode is tried on its own with per-string on-times and delays that differ. One frame primes the frame length and the next frame is checked at every position, so the results show which edge each mode holds fixed. Mixed cases cover the rest. Frames of differing length, some with idle cycles between grayscale pulses, show that the end-anchored modes use the previous frame's pulse count and not cycles. Intensities of 4095, 2048 and 0 show the truncating scale. A late-delay pulse shows the cut at sync. Writes made mid-frame, bypass toggles and out-of-map addresses show that nothing changes before the next sync, or ever for an unused address.

// File: rtl/dim_pkg.sv
package dim_pkg;
  typedef enum logic [1:0] {
    M_FWD = 2'd0,
    M_CTR = 2'd1,
    M_REV = 2'd2,
    M_INV = 2'd3
  } dim_mode_e;
endpackage

// File: rtl/dim_regs.sv
module dim_regs #(
  parameter int N  = 16,
  parameter int CW = 12,
  parameter int AW = 6,
  parameter int DW = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sync_i,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [DW-1:0]        wr_data_i,
  output logic [N-1:0][CW-1:0] act_eff_o,
  output logic [N-1:0][CW-1:0] act_dly_o,
  output logic [N-1:0][1:0]    act_mode_o,
  output logic                 act_byp_o
);
  localparam logic [AW-1:0] A_INT = AW'(2*N);
  localparam logic [AW-1:0] A_BYP = AW'(2*N+1);

  logic [N-1:0][CW-1:0] sh_on, sh_dly;
  logic [N-1:0][1:0]    sh_mode;
  logic [CW-1:0]        sh_int;
  logic                 sh_byp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_int <= '0;
      sh_byp <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_INT) sh_int <= wr_data_i[CW-1:0];
      if (wr_addr_i == A_BYP) sh_byp <= wr_data_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_byp_o <= 1'b0;
    else if (sync_i) act_byp_o <= sh_byp;
  end

  for (genvar g = 0; g < N; g++) begin : g_str
    localparam logic [AW-1:0] A_ON  = AW'(2*g);
    localparam logic [AW-1:0] A_DLY = AW'(2*g+1);
    logic [2*CW-1:0] prod;

    assign prod = {{CW{1'b0}}, sh_on[g]} * {{CW{1'b0}}, sh_int};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_on[g]   <= '0;
        sh_dly[g]  <= '0;
        sh_mode[g] <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == A_ON) sh_on[g] <= wr_data_i[CW-1:0];
        if (wr_addr_i == A_DLY) begin
          sh_dly[g]  <= wr_data_i[CW-1:0];
          sh_mode[g] <= wr_data_i[CW+1:CW];
        end
      end
    end

    // scale once per frame; active set holds the scaled width
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_eff_o[g]  <= '0;
        act_dly_o[g]  <= '0;
        act_mode_o[g] <= '0;
      end else if (sync_i) begin
        act_eff_o[g]  <= prod[2*CW-1:CW];
        act_dly_o[g]  <= sh_dly[g];
        act_mode_o[g] <= sh_mode[g];
      end
    end
  end
endmodule

// File: rtl/dim_frame_timer.sv
module dim_frame_timer #(
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic          gs_en_i,
  output logic [CW-1:0] pos_o,
  output logic [CW-1:0] flen_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o  <= '0;
      flen_o <= '0;
    end else if (sync_i) begin
      pos_o  <= '0;
      flen_o <= pos_o;
    end else if (gs_en_i && pos_o != '1) begin
      pos_o <= pos_o + 1'b1;
    end
  end
endmodule

// File: rtl/dim_edge_calc.sv
module dim_edge_calc #(
  parameter int CW = 12
) (
  input  logic [1:0]    mode_i,
  input  logic [CW-1:0] eff_i,
  input  logic [CW-1:0] dly_i,
  input  logic [CW-1:0] flen_i,
  input  logic [CW-1:0] pos_i,
  output logic          on_o
);
  import dim_pkg::*;
  localparam int W = CW + 1;

  logic [W-1:0] e, d, fl, p, h, rise, fall;

  assign e  = {1'b0, eff_i};
  assign d  = {1'b0, dly_i};
  assign fl = {1'b0, flen_i};
  assign p  = {1'b0, pos_i};
  assign h  = e >> 1;

  always_comb begin
    unique case (dim_mode_e'(mode_i))
      M_FWD: begin
        rise = d;
        fall = d + e;
      end
      M_CTR: begin
        rise = (d >= h) ? d - h : '0;
        fall = d + e - h;
      end
      M_REV: begin
        fall = fl + d;
        rise = (fall >= e) ? fall - e : '0;
      end
      default: begin
        fall = (fl >= d) ? fl - d : '0;
        rise = (fall >= e) ? fall - e : '0;
      end
    endcase
  end

  assign on_o = (eff_i != '0) && (p >= rise) && (p < fall);
endmodule

// File: rtl/frame_pwm_dimmer.sv
module frame_pwm_dimmer #(
  parameter int N  = 16,
  parameter int CW = 12,
  localparam int AW = $clog2(2*N+2),
  localparam int DW = CW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic          gs_en_i,
  input  logic          ext_pwm_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [N-1:0]  str_o
);
  logic [N-1:0][CW-1:0] act_eff, act_dly;
  logic [N-1:0][1:0]    act_mode;
  logic                 act_byp;
  logic [CW-1:0]        pos, flen;
  logic [N-1:0]         gen_on;

  dim_regs #(.N(N), .CW(CW), .AW(AW), .DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .act_eff_o  (act_eff),
    .act_dly_o  (act_dly),
    .act_mode_o (act_mode),
    .act_byp_o  (act_byp)
  );

  dim_frame_timer #(.CW(CW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .gs_en_i (gs_en_i),
    .pos_o   (pos),
    .flen_o  (flen)
  );

  for (genvar g = 0; g < N; g++) begin : g_edge
    dim_edge_calc #(.CW(CW)) u_edge (
      .mode_i (act_mode[g]),
      .eff_i  (act_eff[g]),
      .dly_i  (act_dly[g]),
      .flen_i (flen),
      .pos_i  (pos),
      .on_o   (gen_on[g])
    );
  end

  assign str_o = act_byp ? {N{ext_pwm_i}} : gen_on;
endmodule

// File: rtl/dim_checker.sv
module dim_checker #(
  parameter int N  = 16,
  parameter int CW = 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sync_i,
  input logic                 gs_en_i,
  input logic                 ext_pwm_i,
  input logic [N-1:0]         str_o,
  input logic [CW-1:0]        pos,
  input logic [CW-1:0]        flen,
  input logic                 act_byp,
  input logic [N-1:0][CW-1:0] act_eff,
  input logic [N-1:0][CW-1:0] act_dly,
  input logic [N-1:0][1:0]    act_mode
);
  p_sync_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> pos == '0);

  p_pos_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gs_en_i && !sync_i && pos != '1) |=> pos == $past(pos) + 1'b1);

  p_flen_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> flen == $past(pos));

  p_active_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> $stable(act_eff) && $stable(act_dly) && $stable(act_mode) && $stable(act_byp));

  p_bypass_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_byp |-> str_o == {N{ext_pwm_i}});

  for (genvar g = 0; g < N; g++) begin : g_zero
    p_zero_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!act_byp && act_eff[g] == '0) |-> !str_o[g]);
  end
endmodule

bind frame_pwm_dimmer dim_checker #(.N(N), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sync_i    (sync_i),
  .gs_en_i   (gs_en_i),
  .ext_pwm_i (ext_pwm_i),
  .str_o     (str_o),
  .pos       (pos),
  .flen      (flen),
  .act_byp   (act_byp),
  .act_eff   (act_eff),
  .act_dly   (act_dly),
  .act_mode  (act_mode)
);

// File: tb/sim_frame_pwm_dimmer.sv
module sim_frame_pwm_dimmer;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 0, rst_n = 0;
  logic        sync = 0, gs = 0, ext = 0, we = 0;
  logic [5:0]  waddr = '0;
  logic [13:0] wdata = '0;
  logic [15:0] str;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int s_on[N], s_dly[N], s_mode[N], s_int, s_byp;
  int a_on[N], a_dly[N], a_mode[N], a_int, a_byp;
  int cur_flen = 0, last_len = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_pwm_dimmer u0 (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .gs_en_i(gs), .ext_pwm_i(ext),
    .wr_en_i(we), .wr_addr_i(waddr), .wr_data_i(wdata), .str_o(str)
  );

  function automatic bit exp_bit(int m, int on, int dly, int inten, int fl, int p);
    int eff, r, f, h;
    eff = (on * inten) >> 12;
    if (eff == 0) return 0;
    case (m)
      0: begin r = dly; f = dly + eff; end
      1: begin h = eff / 2; r = (dly >= h) ? dly - h : 0; f = dly + eff - h; end
      2: begin f = fl + dly; r = (f >= eff) ? f - eff : 0; end
      default: begin f = (fl >= dly) ? fl - dly : 0; r = (f >= eff) ? f - eff : 0; end
    endcase
    return (p >= r) && (p < f);
  endfunction

  function automatic logic [15:0] exp_vec(int p);
    logic [15:0] v;
    if (a_byp != 0) return {16{ext}};
    for (int i = 0; i < N; i++) v[i] = exp_bit(a_mode[i], a_on[i], a_dly[i], a_int, cur_flen, p);
    return v;
  endfunction

  task automatic chk(string req, logic [15:0] exp);
    n_chk++;
    if (str !== exp) begin
      n_bad++;
      $display("FAIL %s: str_o=%h expected %h", req, str, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); we = 1; waddr = 6'(a); wdata = 14'(d);
    @(negedge clk); we = 0;
  endtask

  task automatic set_str(int i, int m, int on, int dly);
    s_mode[i] = m; s_on[i] = on; s_dly[i] = dly;
    wr(2*i, on);
    wr(2*i+1, (m << 12) | dly);
  endtask

  task automatic set_int(int v);  s_int = v; wr(32, v); endtask
  task automatic set_byp(int v);  s_byp = v; wr(33, v); endtask

  task automatic run_frame(int len, bit gap, bit chk_en, string req);
    @(negedge clk); sync = 1; gs = 0;
    @(negedge clk); sync = 0;
    a_on = s_on; a_dly = s_dly; a_mode = s_mode; a_int = s_int; a_byp = s_byp;
    cur_flen = last_len;
    for (int p = 0; p < len; p++) begin
      ext = (p % 3 == 0);
      #1;
      if (chk_en) chk(req, exp_vec(p));
      gs = 1;
      @(negedge clk); gs = 0;
      if (gap) @(negedge clk);
    end
    last_len = len;
  endtask

  task automatic t_reset;
    #1 chk("R1 reset", 16'h0);
    run_frame(8, 0, 1, "R1 after first sync");
  endtask

  task automatic t_forward;
    set_int(4095);
    for (int i = 0; i < N; i++) set_str(i, 0, 3 + i*2, i);
    run_frame(40, 0, 0, "R4");
    run_frame(40, 0, 1, "R4 forward");
  endtask

  task automatic t_center;
    for (int i = 0; i < N; i++) set_str(i, 1, 2 + i*3, 4 + i);
    run_frame(40, 0, 0, "R5");
    run_frame(40, 0, 1, "R5 center");
  endtask

  task automatic t_reverse;
    for (int i = 0; i < N; i++) set_str(i, 2, 6 + i*2, i % 5);
    run_frame(36, 0, 0, "R6");
    run_frame(36, 0, 1, "R6 reverse");
  endtask

  task automatic t_inverse;
    for (int i = 0; i < N; i++) set_str(i, 3, 4 + i, 2 + i);
    run_frame(36, 0, 0, "R7");
    run_frame(36, 0, 1, "R7 inverse");
  endtask

  task automatic t_frame_len;
    for (int i = 0; i < N; i++) set_str(i, i % 4, 5 + i, 3 + i);
    run_frame(30, 0, 0, "R3");
    run_frame(50, 1, 1, "R3 flen 30 gapped");
    run_frame(20, 0, 1, "R3 flen 50");
  endtask

  task automatic t_intensity;
    set_int(2048);
    for (int i = 0; i < N; i++) set_str(i, 0, 10 + i*3, i);
    run_frame(40, 0, 1, "R8 half intensity");
    set_int(0);
    run_frame(40, 0, 1, "R8 zero intensity");
    set_int(4095);
  endtask

  task automatic t_trunc;
    for (int i = 0; i < N; i++) set_str(i, 0, (i % 3 == 0) ? 0 : 20, 30);
    run_frame(40, 0, 1, "R9 zero/truncate");
    run_frame(40, 0, 1, "R9 restart after sync");
  endtask

  task automatic t_shadow;
    logic [15:0] snap;
    for (int i = 0; i < N; i++) set_str(i, 0, 4, i);
    run_frame(24, 0, 1, "R2 load");
    #1 snap = str;
    for (int i = 0; i < N; i++) set_str(i, 3, 9, 1);
    #1 chk("R2 shadow hold", snap);
    run_frame(24, 0, 1, "R2 new values");
  endtask

  task automatic t_bypass;
    logic [15:0] snap;
    #1 snap = str;
    set_byp(1);
    @(negedge clk); ext = 1; #1 chk("R10 before sync", snap);
    run_frame(12, 0, 1, "R10 bypass");
    set_byp(0);
    run_frame(24, 0, 1, "R10 bypass off");
  endtask

  task automatic t_regmap;
    for (int i = 0; i < N; i++) set_str(i, i % 4, 7, 2 + i);
    wr(34, 14'h3fff);
    wr(40, 14'h2abc);
    wr(63, 14'h1fff);
    run_frame(30, 0, 1, "R11 unused addr");
    run_frame(30, 0, 1, "R11 map");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin s_on[i] = 0; s_dly[i] = 0; s_mode[i] = 0; end
    s_int = 0; s_byp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_forward();
    t_center();
    t_reverse();
    t_inverse();
    t_frame_len();
    t_intensity();
    t_trunc();
    t_shadow();
    t_bypass();
    t_regmap();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule